// File: doc/BRIEF.md
# Serial Register Read Slave

This block is the device side of a four-wire serial port that answers register reads from an external master. The master pulls the active-low select line down and clocks in one command byte on rising serial-clock edges. The byte holds a 7-bit register address, most significant bit first, followed by a direction flag. When the flag asks for a read, the block presents the address on a parallel lookup port with a one-cycle strobe. It takes the 12-bit value that comes back and returns a 16-bit word whose top four bits are forced to one. The response leaves most significant bit first and changes after falling serial-clock edges.

The serial clock, select and data-in lines are not treated as clocks. All three are oversampled in the system clock domain through two-flop synchronizers, and edges of the serial clock are detected there. A write command is decoded and then discarded. Releasing select at any point returns the engine to the start of a command. The data-out pin is modelled as a value plus a separate output enable, which is active only while select is asserted.

Top module: `spi_regread_slave`

## Requirements
- R1: After reset, `spi_miso`, `spi_miso_oe` and `rd_strobe` are all 0.
- R2: `spi_miso_oe` is 1 while the synchronized select is low and 0 while it is high, so the pin floats between transactions.
- R3: The first 8 bits sampled on rising `spi_sclk` edges after select falls form the command: bits 1 to 7 are the register address (first bit sent = address bit 6), and bit 8 is the direction flag. A read command produces exactly one single-cycle `rd_strobe` pulse, with `rd_addr` equal to the address during that pulse.
- R4: After a read command, the next 16 bits on `spi_miso` form a word sent most significant bit first. Bits 15..12 are all 1 and bits 11..0 equal `rd_data` as sampled in the `rd_strobe` cycle.
- R5: `spi_miso` changes only after a detected falling `spi_sclk` edge or when select is released. It is stable while `spi_sclk` is high.
- R6: A direction flag of 0 (write) produces no `rd_strobe`, and `spi_miso` stays 0 for the whole transaction.
- R7: Raising select in the middle of a command clears the bit counter and shift registers, so the next select-low period decodes a fresh 8-bit command.
- R8: `spi_miso` is 0 before the response starts, after all 16 response bits are sent, and on the cycle after select is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| rd_strobe | output | 1 | One-cycle register read request |
| rd_addr | output | 7 | Register address of the request |
| rd_data | input | 12 | Register value returned by the lookup port in the strobe cycle |

## Verification
The bench reads every one of the 128 addresses from a stub bank whose contents are computed arithmetically. This catches a design that shifts the address in LSB first, forgets the ones padding, or pads the wrong nibble. It checks that the data-out bit holds across every high half of the serial clock, which exposes a shifter that updates on rising edges. Write commands, a select released after four command bits, and extra clocks past the sixteenth response bit are also applied. A design that strobes on writes, keeps stale bits after an abort, or recirculates the word instead of shifting in zeros would produce wrong bits or strobe counts.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int unsigned DEF_ADDR_W = 7;
    localparam int unsigned DEF_DATA_W = 12;
    localparam int unsigned DEF_PAD_W  = 4;
    localparam int unsigned DEF_SYNC_N = 2;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_FETCH = 2'd1,
        PH_SEND  = 2'd2,
        PH_DROP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic is_read(input logic flag);
        return flag == 1'b1;
    endfunction

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("spi_rd_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], async_i};
    end

    assign level_o = chain[STAGES-1];
endmodule

// File: rtl/spi_rd_edge.sv
module spi_rd_edge
    import spi_rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level_i,
    output edge_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    always_comb begin
        ev_o.rise = level_i & ~prev_q;
        ev_o.fall = ~level_i & prev_q;
    end
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  edge_t             sclk_ev,
    input  logic              din,
    output logic              cmd_done,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              send_en
);
    localparam int unsigned CMD_W = ADDR_W + 1;
    localparam int unsigned CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_W - 1);

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [ADDR_W-1:0] cmd_sh_q;
    logic [ADDR_W-1:0] addr_q;

    assign cmd_done = (phase_q == PH_CMD) && sclk_ev.rise && (bit_cnt_q == LAST_BIT);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_CMD:   if (cmd_done) phase_d = is_read(din) ? PH_FETCH : PH_DROP;
            PH_FETCH: phase_d = PH_SEND;
            PH_SEND:  phase_d = PH_SEND;
            PH_DROP:  phase_d = PH_DROP;
            default:  phase_d = PH_CMD;
        endcase
        if (!cs_act) phase_d = PH_CMD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_CMD;
            bit_cnt_q <= '0;
            cmd_sh_q  <= '0;
            addr_q    <= '0;
        end else begin
            phase_q <= phase_d;
            if (!cs_act) begin
                bit_cnt_q <= '0;
                cmd_sh_q  <= '0;
            end else if (phase_q == PH_CMD && sclk_ev.rise) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                cmd_sh_q  <= {cmd_sh_q[ADDR_W-2:0], din};
                if (cmd_done && is_read(din)) addr_q <= cmd_sh_q;
            end
        end
    end

    assign rd_strobe = (phase_q == PH_FETCH);
    assign rd_addr   = addr_q;
    assign send_en   = (phase_q == PH_SEND);
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned PAD_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              miso,
    output logic              miso_oe
);
    localparam int unsigned WORD_W = DATA_W + PAD_W;

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= cs_act;
            if (!cs_act) begin
                sh_q <= '0;
                miso <= 1'b0;
            end else if (load) begin
                sh_q <= {{PAD_W{1'b1}}, load_data};
            end else if (shift) begin
                miso <= sh_q[WORD_W-1];
                sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_regread_slave.sv
module spi_regread_slave
    import spi_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned PAD_W  = DEF_PAD_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    logic  sclk_s, cs_n_s, din_s;
    logic  cs_act;
    edge_t sclk_ev;
    logic  sclk_fall;
    logic  cmd_done;
    logic  send_en;

    spi_rd_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .async_i(spi_sclk), .level_o(sclk_s));
    spi_rd_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .async_i(spi_cs_n), .level_o(cs_n_s));
    spi_rd_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst(rst), .async_i(spi_mosi), .level_o(din_s));

    assign cs_act = ~cs_n_s;

    spi_rd_edge u_edge (
        .clk(clk), .rst(rst), .level_i(sclk_s), .ev_o(sclk_ev));

    assign sclk_fall = sclk_ev.fall;

    spi_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_ev(sclk_ev), .din(din_s),
        .cmd_done(cmd_done), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .send_en(send_en));

    spi_rd_tx #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_tx (
        .clk(clk), .rst(rst), .cs_act(cs_act), .load(rd_strobe),
        .load_data(rd_data), .shift(send_en & sclk_fall),
        .miso(spi_miso), .miso_oe(spi_miso_oe));
endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker (
    input logic clk,
    input logic rst,
    input logic spi_miso,
    input logic spi_miso_oe,
    input logic rd_strobe,
    input logic cs_act,
    input logic sclk_fall,
    input logic cmd_done
);
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !rd_strobe);

    assert_strobe_after_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> $past(cmd_done));

    assert_strobe_in_xfer_R2: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> spi_miso_oe);

    assert_miso_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_miso) |-> ($past(sclk_fall) || !$past(cs_act)));

    assert_miso_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_miso);
endmodule

bind spi_regread_slave spi_rd_checker u_chk (.*);

// File: tb/spi_regread_slave_tb.sv
module spi_regread_slave_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe, rd_strobe;
    logic [6:0]  rd_addr;
    logic [11:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    logic [6:0] stb_addr = '0;
    logic [11:0] stb_data = '0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [11:0] regval(input logic [6:0] a);
        return {a[4:0], a} ^ 12'h9C3;
    endfunction

    assign rd_data = regval(rd_addr);

    spi_regread_slave u_dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data));

    always @(posedge clk) if (rd_strobe) begin
        stb_cnt  <= stb_cnt + 1;
        stb_addr <= rd_addr;
        stb_data <= rd_data;
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        spi_mosi = b;
        waitn(HALF);
        spi_sclk = 1'b1;
        waitn(HALF);
        spi_sclk = 1'b0;
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input int extra,
                        output logic [15:0] w, output logic [3:0] tail,
                        output int unstable, output logic oe_mid);
        logic b0, b1;
        unstable = 0; w = '0; tail = '0;
        spi_cs_n = 1'b0;
        waitn(HALF);
        oe_mid = spi_miso_oe;
        for (int i = 0; i < 8; i++) send_bit(i < 7 ? a[6-i] : rw);
        spi_mosi = 1'b0;
        for (int i = 0; i < 16 + extra; i++) begin
            waitn(HALF);
            b0 = spi_miso;
            spi_sclk = 1'b1;
            waitn(HALF - 1);
            b1 = spi_miso;
            if (b0 !== b1) unstable++;
            waitn(1);
            spi_sclk = 1'b0;
            if (i < 16) w = {w[14:0], b0};
            else if (i < 20) tail = {tail[2:0], b0};
        end
        waitn(4);
        spi_cs_n = 1'b1;
        waitn(10);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] w;
        logic [3:0]  tail;
        int          unst;
        logic        oe_mid;
        int          s0;

        waitn(5);
        check("R1 miso after reset", spi_miso, 0);
        check("R1 oe after reset", spi_miso_oe, 0);
        check("R1 strobe after reset", rd_strobe, 0);
        rst = 1'b0;
        waitn(5);

        // R4 R3 R5: sweep every address
        for (int a = 0; a < 128; a++) begin
            s0 = stb_cnt;
            xfer(7'(a), 1'b1, 0, w, tail, unst, oe_mid);
            check("R4 read word", w, {4'hF, regval(7'(a))});
            check("R3 one strobe", stb_cnt - s0, 1);
            check("R3 strobe address", stb_addr, a);
            check("R5 miso stable while sclk high", unst, 0);
            if (a == 0) begin
                check("R2 oe during transfer", oe_mid, 1);
                check("R2 oe after release", spi_miso_oe, 0);
                check("R8 miso after release", spi_miso, 0);
            end
        end

        // R6: writes are ignored
        for (int k = 0; k < 4; k++) begin
            logic [6:0] a;
            a = 7'(k * 37 + 5);
            s0 = stb_cnt;
            xfer(a, 1'b0, 4, w, tail, unst, oe_mid);
            check("R6 write gives no strobe", stb_cnt - s0, 0);
            check("R6 write keeps miso low", {w, tail}, 0);
        end

        // R7: abort after four command bits, then a fresh read
        spi_cs_n = 1'b0;
        waitn(HALF);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        spi_cs_n = 1'b1;
        waitn(10);
        s0 = stb_cnt;
        xfer(7'h15, 1'b1, 0, w, tail, unst, oe_mid);
        check("R7 read after abort", w, {4'hF, regval(7'h15)});
        check("R7 strobe after abort", stb_cnt - s0, 1);
        check("R7 address after abort", stb_addr, 7'h15);

        // R8: bits past the sixteenth are zero
        xfer(7'h7F, 1'b1, 4, w, tail, unst, oe_mid);
        check("R8 word before tail", w, {4'hF, regval(7'h7F)});
        check("R8 tail bits zero", tail, 0);
        check("R4 strobe data captured", stb_data, regval(7'h7F));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule